// File: doc/BRIEF.md
# Gearbox Transmit Sequence Controller

This block sits in user logic in front of a transmit gearbox whose sequence count is supplied from outside. It keeps a 7-bit sequence count and presents it to the gearbox. It also presents the 3-bit sync header and the data word, and it tells the upstream data source when to hold its data.

Two static inputs set how it runs. The first selects 64B/66B or 64B/67B framing, and that choice sets where the count wraps. The second selects a 2-byte or a 4-byte data interface, and that choice sets how often the count steps. In 2-byte mode the count steps every second user clock cycle. In 4-byte mode it steps on every cycle.

During the slot that holds the final count value, the gearbox takes no new data, and the block raises its pause output for the whole of that slot. The block runs on a single user clock and has a synchronous active-high reset.

Top module: `gearbox_seq_ctrl`

## Requirements
- R1: With `encSel67` = 0 (64B/66B), the sequence count goes 0, 1, …, 32 and then returns to 0.
- R2: With `encSel67` = 1 (64B/67B), the sequence count goes 0, 1, …, 66 and then returns to 0.
- R3: With `width4B` = 1 (4-byte interface), the sequence count advances on every clock cycle.
- R4: With `width4B` = 0 (2-byte interface), each count value is held for exactly two cycles. The first step after reset comes on the second rising edge after reset is released.
- R5: With `encSel67` = 0, bit 6 of `seqOut` is always 0.
- R6: `hdrOut[1:0]` equals `hdrIn[1:0]`. `hdrOut[2]` equals `hdrIn[2]` when `encSel67` = 1 and is forced to 0 when `encSel67` = 0.
- R7: With `width4B` = 1, `dataOut` equals `dataIn`. With `width4B` = 0, `dataOut[15:0]` equals `dataIn[15:0]` and `dataOut[31:16]` is 0.
- R8: `srcPause` is 1 exactly while the count holds its final value (32 or 66, depending on the encoding). In 2-byte mode this covers both cycles of that slot.
- R9: While `rst` is high, `seqOut` is 0. After release, the count starts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high |
| encSel67 | input | 1 | Framing select: 0 = 64B/66B, 1 = 64B/67B (static) |
| width4B | input | 1 | Interface select: 0 = 2-byte, 1 = 4-byte (static) |
| hdrIn | input | 3 | Sync header from the data source |
| dataIn | input | 32 | Data word from the data source |
| seqOut | output | 7 | Sequence count to the gearbox |
| hdrOut | output | 3 | Header to the gearbox |
| dataOut | output | 32 | Data to the gearbox |
| srcPause | output | 1 | Hold request to the data source |

## Verification
The assertions assume that `encSel67` and `width4B` stay constant for as long as `rst` is low. A count left over from a different wrap point would break the range and cadence properties. To respect this, the bench changes either select only while reset is held. It then releases reset and runs several full wrap periods in each of the four configurations. `hdrIn` and `dataIn` are unconstrained, so they are drawn at random on every cycle.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  typedef struct packed {
    logic advance;  // step the count this cycle
    logic clear;    // return to zero instead of stepping
  } gbxStrobes_t;
endpackage

// File: rtl/gbx_ctrl.sv
module gbx_ctrl
  import gbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        width4B,
  input  logic        atLast,
  output gbxStrobes_t strobes
);
  logic halfPhase;

  always_ff @(posedge clk) begin
    if (rst)          halfPhase <= 1'b0;
    else if (width4B) halfPhase <= 1'b0;
    else              halfPhase <= ~halfPhase;
  end

  always_comb begin
    strobes.advance = width4B | halfPhase;
    strobes.clear   = strobes.advance & atLast;
  end

  // R4
  half_cadence_chk: assert property (@(posedge clk) disable iff (rst)
    (!width4B && strobes.advance) |=> !strobes.advance);

  // R3
  full_cadence_chk: assert property (@(posedge clk) disable iff (rst)
    width4B |-> strobes.advance);
endmodule

// File: rtl/gbx_datapath.sv
module gbx_datapath
  import gbx_pkg::*;
#(
  parameter int SEQ_W  = 7,
  parameter int HDR_W  = 3,
  parameter int DATA_W = 32,
  parameter int LAST66 = 32,
  parameter int LAST67 = 66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              encSel67,
  input  logic              width4B,
  input  gbxStrobes_t       strobes,
  input  logic [HDR_W-1:0]  hdrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              atLast,
  output logic [SEQ_W-1:0]  seqOut,
  output logic [HDR_W-1:0]  hdrOut,
  output logic [DATA_W-1:0] dataOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [SEQ_W-1:0] LAST66_V = SEQ_W'(LAST66);
  localparam logic [SEQ_W-1:0] LAST67_V = SEQ_W'(LAST67);

  logic [SEQ_W-1:0] seqCnt;
  logic [SEQ_W-1:0] lastVal;

  assign lastVal = encSel67 ? LAST67_V : LAST66_V;
  assign atLast  = (seqCnt >= lastVal);

  always_ff @(posedge clk) begin
    if (rst)                 seqCnt <= '0;
    else if (strobes.clear)  seqCnt <= '0;
    else if (strobes.advance) seqCnt <= seqCnt + 1'b1;
  end

  always_comb begin
    seqOut = seqCnt;
    seqOut[SEQ_W-1] = encSel67 & seqCnt[SEQ_W-1];
    hdrOut = hdrIn;
    hdrOut[HDR_W-1] = encSel67 & hdrIn[HDR_W-1];
  end

  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      if (g < HALF_W) begin : g_lo
        assign dataOut[g] = dataIn[g];
      end else begin : g_hi
        assign dataOut[g] = width4B & dataIn[g];
      end
    end
  endgenerate

  // R1
  wrap66_chk: assert property (@(posedge clk) disable iff (rst)
    !encSel67 |-> seqOut <= SEQ_W'(LAST66));

  // R2
  wrap67_chk: assert property (@(posedge clk) disable iff (rst)
    encSel67 |-> seqOut <= SEQ_W'(LAST67));

  // R5
  seq_msb_low_chk: assert property (@(posedge clk) disable iff (rst)
    !encSel67 |-> !seqOut[SEQ_W-1]);

  // R6
  hdr_msb_low_chk: assert property (@(posedge clk) disable iff (rst)
    !encSel67 |-> !hdrOut[HDR_W-1]);

  // R3
  full_step_chk: assert property (@(posedge clk) disable iff (rst)
    width4B |=> seqOut != $past(seqOut));

  // R8
  pause_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (width4B && atLast) |=> seqOut == '0);
endmodule

// File: rtl/gearbox_seq_ctrl.sv
module gearbox_seq_ctrl
  import gbx_pkg::*;
#(
  parameter int SEQ_W  = 7,
  parameter int HDR_W  = 3,
  parameter int DATA_W = 32,
  parameter int LAST66 = 32,
  parameter int LAST67 = 66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              encSel67,
  input  logic              width4B,
  input  logic [HDR_W-1:0]  hdrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [SEQ_W-1:0]  seqOut,
  output logic [HDR_W-1:0]  hdrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              srcPause
);
  gbxStrobes_t strobes;
  logic        atLast;

  gbx_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .width4B (width4B),
    .atLast  (atLast),
    .strobes (strobes)
  );

  gbx_datapath #(
    .SEQ_W (SEQ_W), .HDR_W (HDR_W), .DATA_W (DATA_W),
    .LAST66(LAST66), .LAST67(LAST67)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .encSel67 (encSel67),
    .width4B  (width4B),
    .strobes  (strobes),
    .hdrIn    (hdrIn),
    .dataIn   (dataIn),
    .atLast   (atLast),
    .seqOut   (seqOut),
    .hdrOut   (hdrOut),
    .dataOut  (dataOut)
  );

  assign srcPause = atLast;

  // R9
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> seqOut == '0);
endmodule

// File: tb/gearbox_seq_ctrl_bench.sv
module gearbox_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        encSel67 = 1'b0;
  logic        width4B = 1'b0;
  logic [2:0]  hdrIn = '0;
  logic [31:0] dataIn = '0;
  logic [6:0]  seqOut;
  logic [2:0]  hdrOut;
  logic [31:0] dataOut;
  logic        srcPause;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gearbox_seq_ctrl u_gearbox_seq_ctrl (
    .clk(clk), .rst(rst), .encSel67(encSel67), .width4B(width4B),
    .hdrIn(hdrIn), .dataIn(dataIn), .seqOut(seqOut), .hdrOut(hdrOut),
    .dataOut(dataOut), .srcPause(srcPause)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expHdr(logic m67, logic [2:0] h);
    return {m67 & h[2], h[1:0]};
  endfunction

  function automatic logic [31:0] expData(logic w4, logic [31:0] d);
    return w4 ? d : {16'h0, d[15:0]};
  endfunction

  function automatic int lastOf(logic m67);
    return m67 ? 66 : 32;
  endfunction

  task automatic runCfg(logic m67, logic w4, int cycles);
    int mCnt = 0;
    bit mPh = 0;
    int wraps = 0;
    int pauseCycles = 0;
    @(negedge clk);
    rst = 1'b1;
    encSel67 = m67;
    width4B = w4;
    @(negedge clk);
    @(negedge clk);
    chk("R9 count in reset", 32'(seqOut), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      hdrIn = 3'($urandom);
      dataIn = $urandom;
      #1;
      chk(m67 ? "R2 sequence" : "R1 sequence", 32'(seqOut), 32'(mCnt));
      if (!m67) chk("R5 seq bit6", 32'(seqOut[6]), 32'd0);
      chk("R6 header", 32'(hdrOut), 32'(expHdr(m67, hdrIn)));
      chk("R7 data", dataOut, expData(w4, dataIn));
      chk("R8 pause", 32'(srcPause), 32'(mCnt == lastOf(m67)));
      if (srcPause) pauseCycles++;
      @(posedge clk);
      if (w4 || mPh) begin
        if (mCnt >= lastOf(m67)) begin mCnt = 0; wraps++; end
        else mCnt = mCnt + 1;
      end
      mPh = w4 ? 1'b0 : ~mPh;
      @(negedge clk);
    end
    // Directed cadence check: number of pause cycles per wrap
    if (wraps > 0)
      chk(w4 ? "R3 pause cycles per wrap" : "R4 pause cycles per wrap",
          32'(pauseCycles >= (w4 ? wraps : 2 * wraps)), 32'd1);
  endtask

  task automatic firstStep2B();
    // R4: first advance on the second rising edge after release
    @(negedge clk);
    rst = 1'b1; encSel67 = 1'b0; width4B = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 held after first edge", 32'(seqOut), 32'd0);
    @(negedge clk);
    chk("R4 step after second edge", 32'(seqOut), 32'd1);
    @(negedge clk);
    chk("R4 held after third edge", 32'(seqOut), 32'd1);
    @(negedge clk);
    chk("R4 step after fourth edge", 32'(seqOut), 32'd2);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    firstStep2B();
    runCfg(1'b0, 1'b1, 120);
    runCfg(1'b1, 1'b1, 210);
    runCfg(1'b0, 1'b0, 150);
    runCfg(1'b1, 1'b0, 290);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule